// File: doc/BRIEF.md
# Bit-Reversed Pointer Update Unit

This unit sits in the address path of a 16-bit, word-oriented data memory and computes the post-access value of a pointer register. One pointer may be chosen by configuration. When writes of whole words go through that pointer with an auto-incrementing indirect mode, it steps through a buffer in bit-reversed index order. Copying a sequential array through such a pointer reorders radix-2 FFT data. All other accesses receive an ordinary increment or decrement.

The configuration has three parts: a pointer-select code, an enable bit and a modifier. The modifier is set to half the buffer length counted in words and acts on byte-address bits 15:1. Each access presents the register index, the current pointer, size, direction and addressing mode. One clock later the unit returns the write-back pointer, the effective memory address and a flag that shows whether the reversed update was taken.

Top module: `brev_ptr_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `upd_valid`, `upd_ptr`, `upd_addr` and `upd_brev` are all 0.
- R2: The reversed update is taken (`upd_brev`=1) only when all of these hold: `cfg_en`=1, `acc_reg` equals `cfg_sel`, `acc_byte`=0, `acc_write`=1, and `acc_mode` is 2'b00 (post-increment) or 2'b01 (pre-increment).
- R3: A `cfg_sel` of 4'b1111 never takes the reversed update, including for accesses through register 15.
- R4: When the update is taken, the word index `acc_ptr[15:1]` is added to `cfg_mod` with the carry moving from the high bits toward bit 1. Any carry out below bit 1 is discarded.
- R5: When the update is taken, bit 0 of the pointer is unchanged. Pointer bits above the highest set bit of `cfg_mod` are also unchanged.
- R6: Start from a base aligned to 2·N bytes, with `cfg_mod`=N/2 and N a power of two from 2 to 1024. Repeated updates then visit byte address base + 2·bitrev(i) for i = 0..N-1, and step N returns to the base.
- R7: When the update is not taken, mode 2'b00 or 2'b01 adds 2 for a word access or 1 for a byte access. Mode 2'b10 (post-decrement) or 2'b11 (pre-decrement) subtracts the same amount. The result wraps modulo 2^16.
- R8: `upd_addr` equals the old pointer for post modes (`acc_mode[0]`=0) and the new pointer for pre modes (`acc_mode[0]`=1).
- R9: Results appear with `upd_valid`=1 exactly one cycle after `acc_valid`=1. When no access is presented, `upd_valid` is 0 in the next cycle and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 4 | Pointer selected for reversed stepping; all ones disables |
| cfg_en | input | 1 | Reversed stepping enable |
| cfg_mod | input | 15 | Modifier in words (half the buffer length) |
| acc_valid | input | 1 | Access presented this cycle |
| acc_reg | input | 4 | Index of the pointer register used |
| acc_ptr | input | 16 | Current pointer value |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | 00 post-inc, 01 pre-inc, 10 post-dec, 11 pre-dec |
| upd_valid | output | 1 | Result valid |
| upd_ptr | output | 16 | Pointer write-back value |
| upd_addr | output | 16 | Effective memory address |
| upd_brev | output | 1 | Reversed update was taken |

## Verification
The assertions assume that the configuration inputs are stable while an access is in flight. They also assume that no access inputs are X while `acc_valid` is high, because several properties compare against `$past` of the pointer. The bench changes configuration only between accesses, with `acc_valid` low, and it drives every access field on every access. Random accesses mix qualifying and non-qualifying field combinations, and random non-power-of-two modifiers exercise the general reverse-carry rule. Buffer sweeps use only aligned bases, so the visiting-order check rests on a valid assumption.

// File: rtl/brev_pkg.sv
package brev_pkg;
  typedef enum logic [1:0] {
    AM_POST_INC = 2'b00,
    AM_PRE_INC  = 2'b01,
    AM_POST_DEC = 2'b10,
    AM_PRE_DEC  = 2'b11
  } amode_e;

  function automatic logic mode_is_pre(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_is_dec(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/brev_qualify.sv
module brev_qualify #(
  parameter int SELW = 4
) (
  input  logic            cfg_en,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [SELW-1:0] acc_reg,
  input  logic            acc_byte,
  input  logic            acc_write,
  input  logic [1:0]      acc_mode,
  output logic            qual_hit
);
  import brev_pkg::*;
  localparam logic [SELW-1:0] OFF_CODE = '1;

  logic sel_live, reg_match, kind_ok;

  always_comb begin
    sel_live  = cfg_en && (cfg_sel != OFF_CODE);
    reg_match = (acc_reg == cfg_sel);
    kind_ok   = !acc_byte && acc_write && !mode_is_dec(acc_mode);
    qual_hit  = sel_live && reg_match && kind_ok;
  end
endmodule

// File: rtl/brev_rcadd.sv
module brev_rcadd #(
  parameter int WW = 15
) (
  input  logic [WW-1:0] widx,
  input  logic [WW-1:0] wmod,
  output logic [WW-1:0] widx_next
);
  logic [WW-1:0] rev_idx, rev_mod, rev_sum;

  for (genvar b = 0; b < WW; b++) begin : g_rev
    assign rev_idx[b]        = widx[WW-1-b];
    assign rev_mod[b]        = wmod[WW-1-b];
    assign widx_next[b]      = rev_sum[WW-1-b];
  end

  // forward add in the mirrored domain = carry toward LSB in the real one
  assign rev_sum = rev_idx + rev_mod;
endmodule

// File: rtl/brev_linear.sv
module brev_linear #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic          is_byte,
  input  logic          is_dec,
  output logic [AW-1:0] ptr_next
);
  logic [AW-1:0] step;

  always_comb begin
    step     = is_byte ? AW'(1) : AW'(2);
    ptr_next = is_dec ? (ptr - step) : (ptr + step);
  end
endmodule

// File: rtl/brev_ptr_unit.sv
module brev_ptr_unit #(
  parameter int AW   = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] cfg_sel,
  input  logic            cfg_en,
  input  logic [AW-2:0]   cfg_mod,
  input  logic            acc_valid,
  input  logic [SELW-1:0] acc_reg,
  input  logic [AW-1:0]   acc_ptr,
  input  logic            acc_byte,
  input  logic            acc_write,
  input  logic [1:0]      acc_mode,
  output logic            upd_valid,
  output logic [AW-1:0]   upd_ptr,
  output logic [AW-1:0]   upd_addr,
  output logic            upd_brev
);
  import brev_pkg::*;
  localparam int WW = AW - 1;

  logic          qual_hit;
  logic [WW-1:0] rc_widx;
  logic [AW-1:0] rc_ptr, lin_ptr, nxt_ptr, nxt_addr;

  brev_qualify #(.SELW(SELW)) u_qual (
    .cfg_en   (cfg_en),
    .cfg_sel  (cfg_sel),
    .acc_reg  (acc_reg),
    .acc_byte (acc_byte),
    .acc_write(acc_write),
    .acc_mode (acc_mode),
    .qual_hit (qual_hit)
  );

  brev_rcadd #(.WW(WW)) u_rc (
    .widx     (acc_ptr[AW-1:1]),
    .wmod     (cfg_mod),
    .widx_next(rc_widx)
  );

  brev_linear #(.AW(AW)) u_lin (
    .ptr     (acc_ptr),
    .is_byte (acc_byte),
    .is_dec  (mode_is_dec(acc_mode)),
    .ptr_next(lin_ptr)
  );

  always_comb begin
    rc_ptr   = {rc_widx, acc_ptr[0]};
    nxt_ptr  = qual_hit ? rc_ptr : lin_ptr;
    nxt_addr = mode_is_pre(acc_mode) ? nxt_ptr : acc_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_ptr   <= '0;
      upd_addr  <= '0;
      upd_brev  <= 1'b0;
    end else begin
      upd_valid <= acc_valid;
      if (acc_valid) begin
        upd_ptr  <= nxt_ptr;
        upd_addr <= nxt_addr;
        upd_brev <= qual_hit;
      end
    end
  end
endmodule

// File: rtl/brev_ptr_unit_chk.sv
module brev_ptr_unit_chk #(
  parameter int AW   = 16,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SELW-1:0] cfg_sel,
  input logic            acc_valid,
  input logic [AW-1:0]   acc_ptr,
  input logic            acc_byte,
  input logic            acc_write,
  input logic [1:0]      acc_mode,
  input logic            upd_valid,
  input logic [AW-1:0]   upd_ptr,
  input logic [AW-1:0]   upd_addr,
  input logic            upd_brev
);
  p_byte_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_byte) |=> !upd_brev);
  p_read_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> !upd_brev);
  p_dec_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode[1]) |=> !upd_brev);
  p_sp_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cfg_sel == '1) |=> !upd_brev);
  p_bit0_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (!upd_brev || upd_ptr[0] == $past(acc_ptr[0])));
  p_byte_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_byte && !acc_mode[1]) |=> upd_ptr == AW'($past(acc_ptr) + 1));
  p_post_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_mode[0]) |=> upd_addr == $past(acc_ptr));
  p_pre_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_mode[0]) |=> upd_addr == upd_ptr);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> upd_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!upd_valid && $stable(upd_ptr) && $stable(upd_addr)));
endmodule

bind brev_ptr_unit brev_ptr_unit_chk #(.AW(AW), .SELW(SELW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .acc_valid(acc_valid),
  .acc_ptr(acc_ptr), .acc_byte(acc_byte), .acc_write(acc_write),
  .acc_mode(acc_mode), .upd_valid(upd_valid), .upd_ptr(upd_ptr),
  .upd_addr(upd_addr), .upd_brev(upd_brev)
);

// File: tb/brev_ptr_unit_tb_top.sv
module brev_ptr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_sel = 4'd0;
  logic        cfg_en = 1'b0;
  logic [14:0] cfg_mod = 15'd0;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_reg = 4'd0;
  logic [15:0] acc_ptr = 16'd0;
  logic        acc_byte = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_mode = 2'b00;
  logic        upd_valid, upd_brev;
  logic [15:0] upd_ptr, upd_addr;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brev_ptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_mod(cfg_mod), .acc_valid(acc_valid), .acc_reg(acc_reg),
    .acc_ptr(acc_ptr), .acc_byte(acc_byte), .acc_write(acc_write),
    .acc_mode(acc_mode), .upd_valid(upd_valid), .upd_ptr(upd_ptr),
    .upd_addr(upd_addr), .upd_brev(upd_brev)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bitrev(input int i, input int k);
    int r = 0;
    for (int j = 0; j < k; j++) if (i[j]) r[k-1-j] = 1'b1;
    return r;
  endfunction

  function automatic logic model_qual(input logic en, input logic [3:0] sel,
      input logic [3:0] rg, input logic by, input logic wr, input logic [1:0] md);
    return en && (sel != 4'hF) && (rg == sel) && !by && wr && !md[1];
  endfunction

  // bit-serial reverse-carry: walk from MSB of the word index down to bit 0
  function automatic logic [15:0] model_next(input logic q, input logic [15:0] p,
      input logic [14:0] m, input logic by, input logic [1:0] md);
    logic [15:0] r;
    logic c;
    if (q) begin
      r = p;
      c = 1'b0;
      for (int b = 14; b >= 0; b--) begin
        r[b+1] = p[b+1] ^ m[b] ^ c;
        c = (p[b+1] & m[b]) | (c & (p[b+1] ^ m[b]));
      end
    end else begin
      r = md[1] ? p - (by ? 16'd1 : 16'd2) : p + (by ? 16'd1 : 16'd2);
    end
    return r;
  endfunction

  task automatic access(input logic [3:0] rg, input logic [15:0] p,
                        input logic by, input logic wr, input logic [1:0] md);
    @(negedge clk);
    acc_valid = 1'b1; acc_reg = rg; acc_ptr = p;
    acc_byte = by; acc_write = wr; acc_mode = md;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic access_check(input string req, input logic [3:0] rg,
      input logic [15:0] p, input logic by, input logic wr, input logic [1:0] md);
    logic q;
    logic [15:0] e;
    q = model_qual(cfg_en, cfg_sel, rg, by, wr, md);
    e = model_next(q, p, cfg_mod, by, md);
    access(rg, p, by, wr, md);
    check(req, "upd_ptr", upd_ptr, e);
    check("R8", "upd_addr", upd_addr, md[0] ? e : p);
    check(req, "upd_brev", {15'd0, upd_brev}, {15'd0, q});
    check("R9", "upd_valid", {15'd0, upd_valid}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    check("R1", "upd_valid in reset", {15'd0, upd_valid}, 16'd0);
    check("R1", "upd_ptr in reset", upd_ptr, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "upd_addr after reset", upd_addr, 16'd0);
    check("R1", "upd_brev after reset", {15'd0, upd_brev}, 16'd0);

    // directed: spec example 8-word buffer at 0x0100
    cfg_en = 1'b1; cfg_sel = 4'd3; cfg_mod = 15'd4;
    access_check("R4", 4'd3, 16'h0100, 1'b0, 1'b1, 2'b00);
    check("R6", "8-word step 1", upd_ptr, 16'h0108);
    access_check("R4", 4'd3, 16'h0108, 1'b0, 1'b1, 2'b00);
    check("R6", "8-word step 2", upd_ptr, 16'h0104);
    // carry stops below bit 1 and upper bits stay: index 7 -> 0
    access_check("R5", 4'd3, 16'hAB0E, 1'b0, 1'b1, 2'b01);
    check("R5", "wrap keeps upper bits", upd_ptr, 16'hAB00);
    // odd pointer bit 0 untouched
    access_check("R5", 4'd3, 16'h0101, 1'b0, 1'b1, 2'b00);
    check("R5", "bit0 kept", upd_ptr, 16'h0109);

    // fallbacks
    access_check("R2", 4'd3, 16'h0100, 1'b1, 1'b1, 2'b00);
    check("R7", "byte inc", upd_ptr, 16'h0101);
    access_check("R2", 4'd3, 16'h0100, 1'b0, 1'b0, 2'b00);
    check("R7", "read inc", upd_ptr, 16'h0102);
    access_check("R2", 4'd4, 16'h0100, 1'b0, 1'b1, 2'b01);
    check("R7", "other reg inc", upd_ptr, 16'h0102);
    access_check("R7", 4'd3, 16'h0000, 1'b0, 1'b1, 2'b10);
    check("R7", "dec wraps", upd_ptr, 16'hFFFE);
    cfg_en = 1'b0;
    access_check("R2", 4'd3, 16'h0100, 1'b0, 1'b1, 2'b00);
    check("R2", "disabled inc", upd_ptr, 16'h0102);
    cfg_en = 1'b1; cfg_sel = 4'hF;
    access_check("R3", 4'hF, 16'h0100, 1'b0, 1'b1, 2'b00);
    check("R3", "sel 15 inc", upd_ptr, 16'h0102);

    // idle: no valid, outputs hold
    @(negedge clk);
    check("R9", "idle upd_valid", {15'd0, upd_valid}, 16'd0);
    check("R9", "idle hold ptr", upd_ptr, 16'h0102);

    // full sweeps for every buffer size 2..1024 words
    cfg_sel = 4'd7;
    for (int k = 1; k <= 10; k++) begin
      int n;
      logic [15:0] base, p;
      logic [1:0] md;
      n = 1 << k;
      base = 16'($urandom) & ~16'((2 * n) - 1);
      cfg_mod = 15'(n / 2);
      md = (k % 2) ? 2'b00 : 2'b01;
      p = base;
      for (int i = 0; i < n; i++) begin
        access(4'd7, p, 1'b0, 1'b1, md);
        check("R6", "visit order", upd_ptr,
              base + 16'(2 * bitrev((i + 1) % n, k)));
        check("R8", "sweep addr", upd_addr, md[0] ? upd_ptr : p);
        p = upd_ptr;
      end
      check("R6", "back at base", p, base);
    end

    // constrained random mix
    for (int t = 0; t < 3000; t++) begin
      logic [3:0] rg;
      logic [1:0] md;
      if (t % 50 == 0) begin
        cfg_en  = ($urandom % 8) != 0;
        cfg_sel = ($urandom % 6 == 0) ? 4'hF : 4'($urandom);
        cfg_mod = ($urandom % 2) ? 15'(1 << ($urandom % 15)) : 15'($urandom);
      end
      rg = ($urandom % 2) ? cfg_sel : 4'($urandom);
      md = 2'($urandom);
      access_check("R4", rg, 16'($urandom), ($urandom % 4) == 0,
                   ($urandom % 4) != 0, md);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule